// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar as packed BCD bytes: seconds, minutes, hours, date, month, a two-digit year and a century byte, plus a three-bit weekday counter. A tick-enable input drives it. After a fixed number of ticks, set by a parameter, one second has passed. Every rollover carries on the same clock edge, from seconds through minutes, hours, date, month and year up to the century. Month lengths and February in leap years are part of that carry.

The hour runs in 24-hour form or in 12-hour form with a PM flag. One bit of the hour byte selects the form. The weekday counter advances whenever the date advances. It is not derived from the date, so software assigns the weekday numbers any meaning it likes. A byte-wide write port loads any one field per cycle. All fields are readable in parallel at all times.

Top module: `bcd_rtc_core`

## Requirements
- R1: After synchronous reset the fields read as follows: seconds 00, minutes 00, hour byte 0x12 (12-hour form, AM, hour 12), date 01, month 01, year 00, century 0x20 and weekday 0.
- R2: Seconds advance once every TICKS_PER_SEC ticks (default 4). Seconds wrap from 59 to 00 and advance the minutes. Minutes wrap from 59 to 00 and advance the hour. Without a completed second or a write, no field changes.
- R3: Hour byte bit 7 set selects 24-hour form. In that form bits 5:0 count 00 to 23, and 23 wraps to 00 and advances the date.
- R4: Hour byte bit 7 clear selects 12-hour form, with bit 6 as the PM flag (1 = PM). Hour 11 steps to 12 and toggles PM. Hour 12 steps to 01 without touching the date. The date advances only when 11 PM steps to 12 AM.
- R5: Months 04, 06, 09 and 11 have 30 days. Month 02 has 28 or 29 days. All other months have 31 days. After the last day, the date returns to 01 and the month advances.
- R6: February has 29 days whenever the two-digit year is a multiple of 4, year 00 included. There is no century exception.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: A year wrap changes the century from 0x19 to 0x20. With any other century value, the wrap leaves the century unchanged.
- R9: The weekday steps 0,1,...,6,0 once per date advance. Writes to the date, month or year leave it unchanged.
- R10: A write with wr_en_i high loads the field selected by wr_sel_i on the next edge. The select codes are 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 century and 7 weekday. Seconds and minutes keep data bits 6:0, date bits 5:0, month bits 4:0 and weekday bits 2:0. Year and century keep all 8 bits. For the hour, bit 7 is the form, bit 6 is PM and bits 5:0 are the hour. PM is forced to 0 when bit 7 is 1.
- R11: A tick arriving in a write cycle is discarded. No field advances in that cycle, and the tick does not count toward the next second.
- R12: A seconds write restarts the sub-second tick count. The next second completes only after a further TICKS_PER_SEC ticks.
- R13: A field loaded with a value at or above its upper bound wraps at its next advance. For example, date 31 in month 02 goes to date 01 of month 03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Time-base tick enable |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Form bit, PM bit and BCD hour |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| century_o | output | 8 | Century, BCD |
| dow_o | output | 3 | Weekday counter |

## Verification
The hardest event to reach from the ports is the one-edge cascade, in which a single completed second carries all the way into the century. Another is the February boundary under each leap condition. Ticking from reset would take years of simulated seconds to reach either. The stimulus therefore writes every field to just before the boundary, writing the seconds last so that the tick phase is known, and then supplies exactly one second of ticks. Random traffic is mixed in between, with frequent writes of 59 to seconds and minutes. This makes hour and day carries common, and a bench model tracks every field in every cycle.

// File: rtl/rtc_pkg.sv
// Package: shared field codes and BCD helpers for the calendar counter.
// Assumes BCD digits are valid (0-9); callers tolerate out-of-range values
// by comparing with >= against the upper bound.
package rtc_pkg;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4,
        FLD_YEAR  = 3'd5,
        FLD_CENT  = 3'd6,
        FLD_DOW   = 3'd7
    } rtc_field_e;

    // Increment a two-digit packed BCD value by one (no upper wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Leap test on a BCD year: 10 is 2 mod 4, so use tens parity and ones[1:0].
    function automatic logic year_is_leap(input logic [7:0] yr);
        logic [2:0] s;
        s = {1'b0, yr[4], 1'b0} + {1'b0, yr[1:0]};
        return (s[1:0] == 2'b00);
    endfunction

    // Last day of a month as BCD, given BCD month and BCD year.
    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] yr);
        logic [7:0] d;
        case (mon)
            8'h02:                      d = year_is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
// Module: rtc_prescale
// Divides the tick enable down to one pulse per second.
// Assumes hold_i is high in every write cycle so a tick there is discarded;
// clr_i (seconds write) restarts the sub-second count.
module rtc_prescale #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic hold_i,
    input  logic clr_i,
    output logic step_o
);

    generate
        if (TICKS_PER_SEC <= 1) begin : g_direct
            // One tick per second: pass the enable straight through.
            assign step_o = tick_i & ~hold_i & ~clr_i;
        end else begin : g_count
            localparam int CW = $clog2(TICKS_PER_SEC);
            localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

            logic [CW-1:0] cnt_q;
            logic          take;

            assign take   = tick_i & ~hold_i & ~clr_i;
            assign step_o = take & (cnt_q == LAST);

            // Sub-second tick counter with restart on seconds write.
            always_ff @(posedge clk_i) begin
                if (!rst_ni)            cnt_q <= '0;
                else if (clr_i)         cnt_q <= '0;
                else if (take) begin
                    if (cnt_q == LAST)  cnt_q <= '0;
                    else                cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bcd_field.sv
// Module: bcd_field
// One packed-BCD counter field with loadable value and bounds.
// Steps from lo_i up to hi_i and wraps; any value at or above hi_i wraps on
// the next step. Assumes inc_i and wr_i are never high together (the top
// suppresses all steps in write cycles).
module bcd_field #(
    parameter logic [7:0] RST_VAL = 8'h00,
    parameter logic [7:0] WR_MASK = 8'hFF
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       inc_i,
    input  logic       wr_i,
    input  logic [7:0] wr_val_i,
    input  logic [7:0] lo_i,
    input  logic [7:0] hi_i,
    output logic [7:0] val_o,
    output logic       carry_o
);
    import rtc_pkg::*;

    logic [7:0] val_q;
    logic       at_top;

    assign at_top  = (val_q >= hi_i);
    assign carry_o = inc_i & at_top;
    assign val_o   = val_q;

    // Field register: reset, load, or step with wrap.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     val_q <= RST_VAL;
        else if (wr_i)   val_q <= wr_val_i & WR_MASK;
        else if (inc_i)  val_q <= at_top ? lo_i : bcd_inc(val_q);
    end

endmodule

// File: rtl/rtc_hour.sv
// Module: rtc_hour
// Hour counter with 24-hour form and 12-hour form plus PM flag.
// Output byte: bit7 form (1 = 24-hour), bit6 PM, bits5:0 BCD hour.
// day_o pulses on the step that starts a new day. Assumes inc_i and wr_i are
// mutually exclusive.
module rtc_hour (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       inc_i,
    input  logic       wr_i,
    input  logic [7:0] wr_val_i,
    output logic [7:0] hour_o,
    output logic       day_o
);
    import rtc_pkg::*;

    logic       form24_q;
    logic       pm_q;
    logic [5:0] hr_q;
    logic [5:0] hr_nxt;
    logic       pm_nxt;
    logic [7:0] hr_up;

    assign hr_up  = bcd_inc({2'b00, hr_q});
    assign hour_o = {form24_q, pm_q, hr_q};

    // Next-hour and day-carry decision for both hour forms.
    always_comb begin
        hr_nxt = hr_q;
        pm_nxt = pm_q;
        day_o  = 1'b0;
        if (inc_i) begin
            if (form24_q) begin
                if (hr_q >= 6'h23) begin
                    hr_nxt = 6'h00;
                    day_o  = 1'b1;
                end else begin
                    hr_nxt = hr_up[5:0];
                end
            end else begin
                if (hr_q == 6'h11) begin
                    hr_nxt = 6'h12;
                    pm_nxt = ~pm_q;
                    day_o  = pm_q;
                end else if (hr_q >= 6'h12) begin
                    hr_nxt = 6'h01;
                end else begin
                    hr_nxt = hr_up[5:0];
                end
            end
        end
    end

    // Hour state registers: reset to 12 AM in 12-hour form.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            form24_q <= 1'b0;
            pm_q     <= 1'b0;
            hr_q     <= 6'h12;
        end else if (wr_i) begin
            form24_q <= wr_val_i[7];
            pm_q     <= wr_val_i[7] ? 1'b0 : wr_val_i[6];
            hr_q     <= wr_val_i[5:0];
        end else begin
            hr_q     <= hr_nxt;
            pm_q     <= pm_nxt;
        end
    end

endmodule

// File: rtl/bcd_rtc_core.sv
// Module: bcd_rtc_core (top)
// BCD time-of-day and calendar counter. A completed second ripples through
// seconds, minutes, hours, date, month, year and century within one edge.
// Assumes a single write per cycle; a write discards any tick in that cycle.
module bcd_rtc_core #(
    parameter int         TICKS_PER_SEC = 4,
    parameter logic [7:0] CENT_FIRST    = 8'h19,
    parameter logic [7:0] CENT_NEXT     = 8'h20,
    parameter logic [7:0] CENT_RST      = 8'h20,
    parameter int         DOW_DAYS      = 7
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [7:0] century_o,
    output logic [2:0] dow_o
);
    import rtc_pkg::*;

    localparam int         NFIELDS  = 8;
    localparam logic [2:0] DOW_LAST = 3'(DOW_DAYS - 1);

    logic [NFIELDS-1:0] wr_hit;
    logic               sec_step;
    logic               sec_carry, min_carry, day_step;
    logic               date_carry, month_carry, year_carry;
    logic [7:0]         date_hi;
    logic [2:0]         dow_q;
    logic [7:0]         cent_q;

    // One-hot field write decode.
    always_comb begin
        wr_hit = '0;
        if (wr_en_i) wr_hit[wr_sel_i] = 1'b1;
    end

    rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .hold_i (wr_en_i),
        .clr_i  (wr_hit[FLD_SEC]),
        .step_o (sec_step)
    );

    bcd_field #(.RST_VAL(8'h00), .WR_MASK(8'h7F)) u_sec (
        .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_step),
        .wr_i(wr_hit[FLD_SEC]), .wr_val_i(wr_data_i),
        .lo_i(8'h00), .hi_i(8'h59), .val_o(sec_o), .carry_o(sec_carry)
    );

    bcd_field #(.RST_VAL(8'h00), .WR_MASK(8'h7F)) u_min (
        .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_carry),
        .wr_i(wr_hit[FLD_MIN]), .wr_val_i(wr_data_i),
        .lo_i(8'h00), .hi_i(8'h59), .val_o(min_o), .carry_o(min_carry)
    );

    rtc_hour u_hour (
        .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(min_carry),
        .wr_i(wr_hit[FLD_HOUR]), .wr_val_i(wr_data_i),
        .hour_o(hour_o), .day_o(day_step)
    );

    assign date_hi = month_last_day(month_o, year_o);

    bcd_field #(.RST_VAL(8'h01), .WR_MASK(8'h3F)) u_date (
        .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(day_step),
        .wr_i(wr_hit[FLD_DATE]), .wr_val_i(wr_data_i),
        .lo_i(8'h01), .hi_i(date_hi), .val_o(date_o), .carry_o(date_carry)
    );

    bcd_field #(.RST_VAL(8'h01), .WR_MASK(8'h1F)) u_month (
        .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(date_carry),
        .wr_i(wr_hit[FLD_MONTH]), .wr_val_i(wr_data_i),
        .lo_i(8'h01), .hi_i(8'h12), .val_o(month_o), .carry_o(month_carry)
    );

    bcd_field #(.RST_VAL(8'h00), .WR_MASK(8'hFF)) u_year (
        .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(month_carry),
        .wr_i(wr_hit[FLD_YEAR]), .wr_val_i(wr_data_i),
        .lo_i(8'h00), .hi_i(8'h99), .val_o(year_o), .carry_o(year_carry)
    );

    // Century byte: load, or advance from the first to the next century on year wrap.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                                  cent_q <= CENT_RST;
        else if (wr_hit[FLD_CENT])                    cent_q <= wr_data_i;
        else if (year_carry && cent_q == CENT_FIRST)  cent_q <= CENT_NEXT;
    end

    // Weekday counter: steps once per new day, independent of the date value.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                 dow_q <= 3'd0;
        else if (wr_hit[FLD_DOW])    dow_q <= wr_data_i[2:0];
        else if (day_step)           dow_q <= (dow_q >= DOW_LAST) ? 3'd0 : dow_q + 3'd1;
    end

    assign century_o = cent_q;
    assign dow_o     = dow_q;

endmodule

// File: rtl/rtc_core_chk.sv
// Module: rtc_core_chk
// Property checker for bcd_rtc_core, bound to every instance of the top.
// Observes ports plus the internal one-second step and new-day pulse.
module rtc_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [7:0] hour,
    input logic [7:0] date,
    input logic [7:0] month,
    input logic [7:0] year,
    input logic [7:0] century,
    input logic [2:0] dow,
    input logic       sec_step,
    input logic       day_step
);

    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_step && sec == 8'h59) |=> (sec == 8'h00));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_step && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour) &&
                                   $stable(date) && $stable(month) && $stable(year) &&
                                   $stable(century) && $stable(dow)));

    p_pm_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_step && sec == 8'h59 && min == 8'h59 && !hour[7] && hour[5:0] == 6'h11)
        |=> (hour[6] != $past(hour[6]) && hour[5:0] == 6'h12));

    p_day_12h_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (day_step && !hour[7]) |-> (hour[6] && hour[5:0] == 6'h11));

    p_century_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (day_step && month == 8'h12 && date == 8'h31 && year == 8'h99 && century == 8'h19)
        |=> (century == 8'h20));

    p_dow_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (day_step && dow < 3'd6) |=> (dow == $past(dow) + 3'd1));

    p_dow_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (day_step && dow == 3'd6) |=> (dow == 3'd0));

    p_wr_sec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0) |=> (sec == ($past(wr_data) & 8'h7F)));

    p_no_step_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sec_step);

endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .wr_en   (wr_en_i),
    .wr_sel  (wr_sel_i),
    .wr_data (wr_data_i),
    .sec     (sec_o),
    .min     (min_o),
    .hour    (hour_o),
    .date    (date_o),
    .month   (month_o),
    .year    (year_o),
    .century (century_o),
    .dow     (dow_o),
    .sec_step(sec_step),
    .day_step(day_step)
);

// File: tb/sim_bcd_rtc_core.sv
// Bench for bcd_rtc_core: directed corner cases plus seeded random traffic,
// compared each cycle against a calendar model kept in plain integers.
module sim_bcd_rtc_core;

    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o, century_o;
    logic [2:0] dow_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model state
    int m_sec, m_min, m_hr, m_date, m_mon, m_yr, m_cen, m_dow, m_pre;
    bit m_24, m_pm;

    always #10 clk = ~clk;

    bcd_rtc_core #(.TICKS_PER_SEC(TPS)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
        .month_o(month_o), .year_o(year_o), .century_o(century_o), .dow_o(dow_o)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 12; m_24 = 0; m_pm = 0;
        m_date = 1; m_mon = 1; m_yr = 0; m_cen = 20; m_dow = 0; m_pre = 0;
    endtask

    task automatic model_new_day();
        m_dow = (m_dow >= 6) ? 0 : m_dow + 1;
        if (m_date >= days_in(m_mon, m_yr)) begin
            m_date = 1;
            if (m_mon >= 12) begin
                m_mon = 1;
                if (m_yr >= 99) begin
                    m_yr = 0;
                    if (m_cen == 19) m_cen = 20;
                end else m_yr++;
            end else m_mon++;
        end else m_date++;
    endtask

    task automatic model_new_hour();
        if (m_24) begin
            if (m_hr >= 23) begin m_hr = 0; model_new_day(); end
            else m_hr++;
        end else begin
            if (m_hr == 11) begin
                m_hr = 12;
                if (m_pm) model_new_day();
                m_pm = ~m_pm;
            end else if (m_hr >= 12) m_hr = 1;
            else m_hr++;
        end
    endtask

    task automatic model_tick();
        if (m_pre < TPS - 1) begin m_pre++; return; end
        m_pre = 0;
        if (m_sec >= 59) begin
            m_sec = 0;
            if (m_min >= 59) begin m_min = 0; model_new_hour(); end
            else m_min++;
        end else m_sec++;
    endtask

    task automatic model_write(input logic [2:0] sel, input logic [7:0] d);
        case (sel)
            3'd0: begin m_sec = from_bcd(d & 8'h7F); m_pre = 0; end
            3'd1: m_min = from_bcd(d & 8'h7F);
            3'd2: begin m_24 = d[7]; m_pm = d[7] ? 1'b0 : d[6]; m_hr = from_bcd({2'b00, d[5:0]}); end
            3'd3: m_date = from_bcd(d & 8'h3F);
            3'd4: m_mon = from_bcd(d & 8'h1F);
            3'd5: m_yr = from_bcd(d);
            3'd6: m_cen = from_bcd(d);
            default: m_dow = int'(d[2:0]);
        endcase
    endtask

    task automatic check_all(input string tag);
        logic [58:0] act, exp;
        logic [7:0]  hb;
        hb = to_bcd(m_hr);
        hb[7] = m_24;
        hb[6] = m_pm;
        act = {sec_o, min_o, hour_o, date_o, month_o, year_o, century_o, dow_o};
        exp = {to_bcd(m_sec), to_bcd(m_min), hb, to_bcd(m_date), to_bcd(m_mon),
               to_bcd(m_yr), to_bcd(m_cen), 3'(m_dow)};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: fields actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update model, check at the next falling edge.
    task automatic cycle(input bit t, input bit we, input logic [2:0] sel,
                         input logic [7:0] d, input string tag);
        tick = t; wr_en = we; wr_sel = sel; wr_data = d;
        if (we) model_write(sel, d);
        else if (t) model_tick();
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        check_all(tag);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d, input string tag);
        cycle(1'b0, 1'b1, sel, d, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 3'd0, 8'h00, tag);
    endtask

    // Load a moment one second before the end of the day, 24-hour form.
    task automatic set_eod(input logic [7:0] y, input logic [7:0] mo,
                           input logic [7:0] d, input string tag);
        wr(3'd2, 8'hA3, tag);
        wr(3'd1, 8'h59, tag);
        wr(3'd5, y, tag);
        wr(3'd4, mo, tag);
        wr(3'd3, d, tag);
        wr(3'd0, 8'h59, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete (R2)");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1 reset values
        check_all("R1 reset");
        expect8("R1 hour byte", hour_o, 8'h12);
        expect8("R1 century", century_o, 8'h20);

        // R2 prescale: 3 ticks no change, 4th advances seconds
        ticks(3, "R2");
        expect8("R2 sec before 4th tick", sec_o, 8'h00);
        ticks(1, "R2");
        expect8("R2 sec after 4th tick", sec_o, 8'h01);

        // R3 R7 R8 R9 full cascade into the century
        wr(3'd6, 8'h19, "R8");
        wr(3'd7, 8'h06, "R9");
        set_eod(8'h99, 8'h12, 8'h31, "R7");
        ticks(4, "R8 cascade");
        expect8("R3 hour wrap", hour_o, 8'h80);
        expect8("R7 month wrap", month_o, 8'h01);
        expect8("R7 year wrap", year_o, 8'h00);
        expect8("R8 century 19->20", century_o, 8'h20);
        expect8("R9 dow wrap", {5'd0, dow_o}, 8'h00);
        // R8 century stays at 20
        set_eod(8'h99, 8'h12, 8'h31, "R8");
        ticks(4, "R8 stay");
        expect8("R8 century holds", century_o, 8'h20);

        // R6 leap years
        set_eod(8'h24, 8'h02, 8'h28, "R6");
        ticks(4, "R6");
        expect8("R6 leap 24 date", date_o, 8'h29);
        set_eod(8'h24, 8'h02, 8'h29, "R6");
        ticks(4, "R6");
        expect8("R6 leap end month", month_o, 8'h03);
        set_eod(8'h23, 8'h02, 8'h28, "R6");
        ticks(4, "R6");
        expect8("R6 non-leap 23", date_o, 8'h01);
        set_eod(8'h00, 8'h02, 8'h28, "R6");
        ticks(4, "R6");
        expect8("R6 year 00 leap", date_o, 8'h29);

        // R5 month lengths
        set_eod(8'h25, 8'h04, 8'h30, "R5");
        ticks(4, "R5");
        expect8("R5 Apr 30 -> May", month_o, 8'h05);
        set_eod(8'h25, 8'h01, 8'h30, "R5");
        ticks(4, "R5");
        expect8("R5 Jan 30 -> 31", date_o, 8'h31);
        set_eod(8'h25, 8'h11, 8'h30, "R5");
        ticks(4, "R5");
        expect8("R5 Nov 30 -> Dec", month_o, 8'h12);

        // R13 out-of-range date wraps
        set_eod(8'h23, 8'h02, 8'h31, "R13");
        ticks(4, "R13");
        expect8("R13 date", date_o, 8'h01);
        expect8("R13 month", month_o, 8'h03);

        // R4 12-hour form
        wr(3'd3, 8'h10, "R4");
        wr(3'd2, 8'h11, "R4");
        wr(3'd1, 8'h59, "R4");
        wr(3'd0, 8'h59, "R4");
        ticks(4, "R4");
        expect8("R4 11AM -> 12PM", hour_o, 8'h52);
        expect8("R4 no date at noon", date_o, 8'h10);
        wr(3'd1, 8'h59, "R4");
        wr(3'd0, 8'h59, "R4");
        ticks(4, "R4");
        expect8("R4 12PM -> 1PM", hour_o, 8'h41);
        wr(3'd2, 8'h51, "R4");
        wr(3'd1, 8'h59, "R4");
        wr(3'd0, 8'h59, "R4");
        ticks(4, "R4");
        expect8("R4 11PM -> 12AM", hour_o, 8'h12);
        expect8("R4 date advance", date_o, 8'h11);

        // R10 hour write: PM forced clear in 24-hour form; masks
        wr(3'd2, 8'hD5, "R10");
        expect8("R10 hour pm forced", hour_o, 8'h95);
        wr(3'd0, 8'hC7, "R10");
        expect8("R10 sec mask", sec_o, 8'h47);
        // R9 date write leaves weekday
        wr(3'd7, 8'h03, "R9");
        wr(3'd3, 8'h20, "R9");
        expect8("R9 dow after date write", {5'd0, dow_o}, 8'h03);

        // R11 tick in write cycle discarded
        wr(3'd0, 8'h10, "R11");
        ticks(3, "R11");
        cycle(1'b1, 1'b1, 3'd1, 8'h22, "R11");
        expect8("R11 no step on write", sec_o, 8'h10);
        ticks(1, "R11");
        expect8("R11 next tick completes", sec_o, 8'h11);

        // R12 seconds write restarts the count
        ticks(3, "R12");
        wr(3'd0, 8'h30, "R12");
        ticks(3, "R12");
        expect8("R12 held", sec_o, 8'h30);
        ticks(1, "R12");
        expect8("R12 advance", sec_o, 8'h31);

        // Random traffic checked against the model (R2 and carries)
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 10) begin
                logic [2:0] sel;
                logic [7:0] d;
                sel = 3'($urandom % 8);
                case (sel)
                    3'd0, 3'd1: d = ($urandom % 2) ? 8'h59 : to_bcd(int'($urandom % 60));
                    3'd2: begin
                        if ($urandom % 2) d = 8'h80 | to_bcd(int'($urandom % 24));
                        else d = {1'b0, 1'($urandom % 2), 6'(to_bcd(1 + int'($urandom % 12)))};
                    end
                    3'd3: d = to_bcd(1 + int'($urandom % 28));
                    3'd4: d = to_bcd(1 + int'($urandom % 12));
                    3'd5: d = to_bcd(int'($urandom % 100));
                    3'd6: d = ($urandom % 2) ? 8'h19 : 8'h20;
                    default: d = 8'(int'($urandom % 7));
                endcase
                cycle(($urandom % 2) == 1, 1'b1, sel, d, "R2 random");
            end else begin
                cycle(r < 85, 1'b0, 3'd0, 8'h00, "R2 random");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule